// File: doc/BRIEF.md
# Ripple-Chain Unsigned Magnitude Comparator

This block compares two unsigned operands and returns a two-bit verdict. It is purely combinational. It is built as a chain of identical one-bit stages. The stage for the least significant bit starts from an "equal" seed. Each stage takes the verdict from the stage below it and passes an updated verdict to the stage above. When a stage's two operand bits differ, that stage decides the verdict on its own. When they match, the stage forwards whatever arrived from below. As a result, the most significant differing bit has the final say.

The verdict leaving the top stage is the block's main output. Three decoded flags (equal, less, greater) sit beside it for consumers that prefer single wires. The operand width is four bits.

Top module: `ripple_magcmp`

## Requirements
- R1: `verdict` encodes the unsigned relation of `opa` to `opb`: 2'b00 when opa equals opb, 2'b01 when opa is less than opb, 2'b10 when opa is greater than opb.
- R2: When a stage's two operand bits differ, its outgoing verdict is 2'b10 if the `opa` bit is 1 and 2'b01 if the `opb` bit is 1, regardless of the incoming verdict.
- R3: When a stage's two operand bits are equal, its outgoing verdict equals its incoming verdict. At the ports, operands that match in the upper bits are decided by the lower bits.
- R4: The incoming verdict of the bit-0 stage is the equal code 2'b00, so identical operands produce `verdict` 2'b00.
- R5: The code 2'b11 never appears on any stage output or on `verdict`, for any operand pair.
- R6: `is_eq`, `is_lt` and `is_gt` are high exactly when `verdict` is 2'b00, 2'b01 and 2'b10 respectively, and exactly one of them is high for every input.
- R7: The highest bit position where the operands differ determines the verdict, whatever the bits below it hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | First unsigned operand |
| opb | input | 4 | Second unsigned operand |
| verdict | output | 2 | Relation code: 00 equal, 01 opa<opb, 10 opa>opb |
| is_eq | output | 1 | High when the operands are equal |
| is_lt | output | 1 | High when opa is less than opb |
| is_gt | output | 1 | High when opa is greater than opb |

## Verification
The bench applies every one of the 256 operand pairs, one per clock, and compares the results against a plain integer comparison. Pairs that are identical isolate the equal seed at bit 0. Pairs whose highest differing bit sits above opposing lower bits show whether the upper stage overrides the stages below it. Pairs that share their upper bits and differ only low down show that the verdict passes unchanged through matching stages. The flag checks over the same sweep separate a wrong code from a wrong decode.

// File: rtl/ripple_magcmp.sv
module ripple_magcmp #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [1:0]       verdict,
  output logic             is_eq,
  output logic             is_lt,
  output logic             is_gt
);

  localparam int TOP = WIDTH;

  // hi[k]/lo[k]: verdict entering stage k; index TOP is the final result
  logic [TOP:0] hi;
  logic [TOP:0] lo;

  assign hi[0] = 1'b0;
  assign lo[0] = 1'b0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    assign hi[k+1] = (opa[k] & ~opb[k]) | (opa[k] & hi[k]) | (~opb[k] & hi[k]);
    assign lo[k+1] = (~opa[k] & opb[k]) | (~opa[k] & lo[k]) | (opb[k] & lo[k]);
  end

  assign verdict = {hi[TOP], lo[TOP]};
  assign is_eq   = ~hi[TOP] & ~lo[TOP];
  assign is_lt   = ~hi[TOP] &  lo[TOP];
  assign is_gt   =  hi[TOP] & ~lo[TOP];

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      AST_NO_BAD_CODE: assert (!(hi[k+1] && lo[k+1])); // R5
      if (opa[k] != opb[k])
        AST_DIFF_DECIDES: assert ({hi[k+1], lo[k+1]} == {opa[k], opb[k]}); // R2
      else
        AST_SAME_FORWARDS: assert ({hi[k+1], lo[k+1]} == {hi[k], lo[k]}); // R3
    end
    AST_ONE_FLAG: assert ($onehot({is_eq, is_lt, is_gt})); // R6
    AST_EQ_MATCH: assert ((opa == opb) == (verdict == 2'b00)); // R4
    AST_ORDER_MATCH: assert ((opa > opb) == (verdict == 2'b10)); // R1
  end

endmodule

// File: tb/ripple_magcmp_tb.sv
module ripple_magcmp_tb;

  logic       clk = 1'b0;
  logic [3:0] opa = 4'd0;
  logic [3:0] opb = 4'd0;
  logic [1:0] verdict;
  logic       is_eq, is_lt, is_gt;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ripple_magcmp u_dut (
    .opa(opa), .opb(opb), .verdict(verdict),
    .is_eq(is_eq), .is_lt(is_lt), .is_gt(is_gt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, opa, opb, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    chk("R4 initial zero pair", verdict, 0);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(posedge clk);
        opa = 4'(i);
        opb = 4'(j);
        @(negedge clk);
        begin
          int exp_code;
          int top;
          exp_code = (i == j) ? 0 : ((i < j) ? 1 : 2);
          chk("R1 code", verdict, exp_code);
          chk("R5 no 11", (verdict == 2'b11) ? 1 : 0, 0);
          chk("R6 flags", {is_eq, is_lt, is_gt}, (exp_code == 0) ? 4 : ((exp_code == 1) ? 2 : 1));
          if (i == j) chk("R4 equal operands", verdict, 0);
          top = -1;
          for (int k = 0; k < 4; k++) if (((i >> k) & 1) != ((j >> k) & 1)) top = k;
          if (top >= 0) begin
            // highest differing bit alone fixes the code
            chk("R7 top diff bit", verdict, (((i >> top) & 1) == 1) ? 2 : 1);
            if (top == 3) chk("R2 bit3 override", verdict, ((i >> 3) & 1) ? 2 : 1);
            if (top < 3) chk("R3 forwarded through equal upper bits", verdict, exp_code);
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule